// File: doc/BRIEF.md
# Nibble-Wide DRAM Byte Access Sequencer

This block runs byte accesses to a dynamic memory whose data path is only four bits wide. Each access is a fixed slot of eight clock cycles, paced by an eight-bit one-hot phase ring. In one slot the block drives one row address with a single row strobe, then two column addresses, each with its own column strobe. The two column addresses differ only in their least significant bit, and that bit selects which nibble of the byte comes back. The first nibble returned becomes the upper half of the byte and the second becomes the lower half.

The slot goes to one of two requesters. A video fetch wins when it is requested and the non-maskable interrupt inhibit is low. Otherwise the CPU address drives the memory, and the assembled byte is loaded into the CPU read register if the CPU is reading. A granted fetch ends with a one-cycle valid pulse on the video byte. A fetch that was requested but blocked by the inhibit still produces the advance pulse, so the video address generator keeps moving along the screen. The request, the inhibit, the read flag and both addresses are sampled once, in the first cycle of the slot.

Top module: `nibble_dram_seq`

## Requirements
- R1: While reset is asserted and until the first slot drives them, `mem_addr` is 0, the row and column strobes are low, `vid_valid` and `vid_adv` are low, and `cpu_byte` is 0.
- R2: Slot cycles are numbered 0 to 7 from the first clock after reset, and slots repeat every 8 cycles. In cycle 1, `mem_addr` carries the row part of the selected address (address bits 14..7).
- R3: `row_sel` is high in cycles 2 to 7 and low in cycles 0 and 1. `col_sel` is high in cycles 3, 4, 6 and 7 and low otherwise. `col_sel` is never high while `row_sel` is low.
- R4: In cycles 2 to 4, `mem_addr` is {address bits 6..0, 0}. From cycle 5 until the next row is driven, it is {address bits 6..0, 1}.
- R5: The nibble present on `dram_nib` in cycle 3 becomes byte bits 7..4. The nibble present in cycle 6 becomes bits 3..0. A memory word index is {row, column} = row*256 + column.
- R6: The video address is selected when `vid_req` is 1 and `nmi` is 0 in cycle 0. Otherwise the CPU address is selected.
- R7: For a granted video fetch, `vid_valid` is high for exactly one cycle, cycle 7, and `vid_byte` holds the assembled byte. `vid_byte` changes in no other cycle, and `vid_valid` never pulses for a slot that was not granted.
- R8: When the slot is not granted to video and `cpu_rd` was 1 in cycle 0, `cpu_byte` takes the assembled byte in cycle 7. In every other case `cpu_byte` keeps its value.
- R9: `vid_adv` pulses high in cycle 7 of every slot in which `vid_req` was 1 in cycle 0, whether or not `nmi` was 1. In all other cycles it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_req | input | 1 | A video fetch is due in this slot |
| vid_addr | input | 15 | Video fetch byte address |
| cpu_addr | input | 15 | CPU byte address |
| cpu_rd | input | 1 | CPU is reading in this slot |
| nmi | input | 1 | Interrupt inhibit that blocks video fetches |
| dram_nib | input | 4 | Nibble returned by the memory |
| mem_addr | output | 8 | Multiplexed row/column address |
| row_sel | output | 1 | Row strobe, active high |
| col_sel | output | 1 | Column strobe, active high |
| vid_byte | output | 8 | Last assembled video byte |
| vid_valid | output | 1 | One-cycle pulse: `vid_byte` is new |
| vid_adv | output | 1 | One-cycle pulse: advance the video address |
| cpu_byte | output | 8 | Last byte read for the CPU |

## Verification
Every output is registered, so each result appears exactly one cycle after the phase that produces it. The row address appears in cycle 1. The strobes and column addresses follow at the cycles listed in R3 and R4. The byte, valid, advance and CPU read results all appear in cycle 7 of the slot whose cycle 0 sampled the inputs. The bench drives each slot's inputs on the falling edge just before cycle 0 and samples every output on the falling edge in the middle of each cycle of the slot. The memory model in the bench latches the row and column on the strobe rising edges and returns nibbles from a computed function. The expected byte is queued when the slot is issued and compared when `vid_valid` is seen.

// File: rtl/nds_pkg.sv
package nds_pkg;
  localparam int PHASES  = 8;
  localparam int PH_ROW  = 0;  // drive row address
  localparam int PH_COL0 = 1;  // row strobe, first column address
  localparam int PH_CAS0 = 2;  // first column strobe
  localparam int PH_HI   = 3;  // capture upper nibble
  localparam int PH_COL1 = 4;  // drop column strobe, second column address
  localparam int PH_CAS1 = 5;  // second column strobe
  localparam int PH_LO   = 6;  // capture lower nibble, byte complete
  localparam int PH_END  = 7;  // release both strobes
endpackage

// File: rtl/nds_phase.sv
module nds_phase #(
  parameter int N = nds_pkg::PHASES
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [N-1:0] ph
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= N'(1);
    else        ph <= {ph[N-2:0], ph[N-1]};
  end
endmodule

// File: rtl/nds_arb.sv
module nds_arb #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              vid_req,
  input  logic              nmi,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] vid_addr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ADDR_W-1:0] addr_now,
  output logic [ADDR_W-1:0] addr_q,
  output logic              grant_q,
  output logic              due_q,
  output logic              rd_q
);
  logic grant_now;

  assign grant_now = vid_req && !nmi;
  assign addr_now  = grant_now ? vid_addr : cpu_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      grant_q <= 1'b0;
      due_q   <= 1'b0;
      rd_q    <= 1'b0;
    end else if (start) begin
      addr_q  <= addr_now;
      grant_q <= grant_now;
      due_q   <= vid_req;
      rd_q    <= cpu_rd;
    end
  end
endmodule

// File: rtl/nds_addr_mux.sv
module nds_addr_mux #(
  parameter int ROW_W = 8,
  parameter int COL_W = 7,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MA_W = ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph_row,
  input  logic              ph_col0,
  input  logic              ph_cas0,
  input  logic              ph_col1,
  input  logic              ph_cas1,
  input  logic              ph_end,
  input  logic [ADDR_W-1:0] addr_now,
  input  logic [ADDR_W-1:0] addr_q,
  output logic [MA_W-1:0]   ma,
  output logic              ras,
  output logic              cas
);
  function automatic logic [MA_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  function automatic logic [MA_W-1:0] col_of(input logic [ADDR_W-1:0] a, input logic half);
    return {a[COL_W-1:0], half};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma  <= '0;
      ras <= 1'b0;
      cas <= 1'b0;
    end else begin
      if (ph_row) ma <= row_of(addr_now);
      if (ph_col0) begin
        ras <= 1'b1;
        ma  <= col_of(addr_q, 1'b0);
      end
      if (ph_cas0) cas <= 1'b1;
      if (ph_col1) begin
        cas <= 1'b0;
        ma  <= col_of(addr_q, 1'b1);
      end
      if (ph_cas1) cas <= 1'b1;
      if (ph_end) begin
        ras <= 1'b0;
        cas <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nds_assemble.sv
module nds_assemble #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph_hi,
  input  logic              ph_lo,
  input  logic              grant_q,
  input  logic              due_q,
  input  logic              rd_q,
  input  logic [NIB_W-1:0]  nib,
  output logic [BYTE_W-1:0] vid_byte,
  output logic              vid_valid,
  output logic              vid_adv,
  output logic [BYTE_W-1:0] cpu_byte
);
  logic [NIB_W-1:0]  hi_q;
  logic [BYTE_W-1:0] whole;

  assign whole = {hi_q, nib};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      vid_byte  <= '0;
      cpu_byte  <= '0;
      vid_valid <= 1'b0;
      vid_adv   <= 1'b0;
    end else begin
      vid_valid <= ph_lo && grant_q;
      vid_adv   <= ph_lo && due_q;
      if (ph_hi) hi_q <= nib;
      if (ph_lo) begin
        if (grant_q)   vid_byte <= whole;
        else if (rd_q) cpu_byte <= whole;
      end
    end
  end
endmodule

// File: rtl/nibble_dram_seq.sv
module nibble_dram_seq #(
  parameter int ROW_W = 8,
  parameter int COL_W = 7,
  parameter int NIB_W = 4,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MA_W = ROW_W,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_req,
  input  logic [ADDR_W-1:0] vid_addr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              nmi,
  input  logic [NIB_W-1:0]  dram_nib,
  output logic [MA_W-1:0]   mem_addr,
  output logic              row_sel,
  output logic              col_sel,
  output logic [BYTE_W-1:0] vid_byte,
  output logic              vid_valid,
  output logic              vid_adv,
  output logic [BYTE_W-1:0] cpu_byte
);
  import nds_pkg::*;

  logic [PHASES-1:0] ph;
  logic ph_row, ph_col0, ph_cas0, ph_hi, ph_col1, ph_cas1, ph_lo, ph_end;
  logic [ADDR_W-1:0] addr_now, addr_q;
  logic grant_q, due_q, rd_q;

  assign ph_row  = ph[PH_ROW];
  assign ph_col0 = ph[PH_COL0];
  assign ph_cas0 = ph[PH_CAS0];
  assign ph_hi   = ph[PH_HI];
  assign ph_col1 = ph[PH_COL1];
  assign ph_cas1 = ph[PH_CAS1];
  assign ph_lo   = ph[PH_LO];
  assign ph_end  = ph[PH_END];

  nds_phase #(.N(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_n), .ph(ph)
  );

  nds_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .start(ph_row),
    .vid_req(vid_req), .nmi(nmi), .cpu_rd(cpu_rd),
    .vid_addr(vid_addr), .cpu_addr(cpu_addr),
    .addr_now(addr_now), .addr_q(addr_q),
    .grant_q(grant_q), .due_q(due_q), .rd_q(rd_q)
  );

  nds_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .ph_row(ph_row), .ph_col0(ph_col0), .ph_cas0(ph_cas0),
    .ph_col1(ph_col1), .ph_cas1(ph_cas1), .ph_end(ph_end),
    .addr_now(addr_now), .addr_q(addr_q),
    .ma(mem_addr), .ras(row_sel), .cas(col_sel)
  );

  nds_assemble #(.NIB_W(NIB_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .ph_hi(ph_hi), .ph_lo(ph_lo),
    .grant_q(grant_q), .due_q(due_q), .rd_q(rd_q), .nib(dram_nib),
    .vid_byte(vid_byte), .vid_valid(vid_valid), .vid_adv(vid_adv),
    .cpu_byte(cpu_byte)
  );
endmodule

// File: rtl/nds_chk.sv
module nds_chk #(
  parameter int MA_W = 8,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        ph,
  input logic [MA_W-1:0]   ma,
  input logic              ras,
  input logic              cas,
  input logic              vid_valid,
  input logic              vid_adv,
  input logic [BYTE_W-1:0] vid_byte,
  input logic [BYTE_W-1:0] cpu_byte
);
  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ph) == 1); // R2
  AST_ROW_IDLE_SLOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ph[0] |-> !ras && !cas); // R3
  AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    cas |-> ras); // R3
  AST_FIRST_COL_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ph[3] |-> cas && !ma[0]); // R4
  AST_SECOND_COL_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    ph[6] |-> cas && ma[0]); // R4
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |=> !vid_valid); // R7
  AST_VALID_IN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |-> ph[7]); // R7
  AST_VID_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ph[7] |-> $stable(vid_byte)); // R7
  AST_CPU_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ph[7] |-> $stable(cpu_byte)); // R8
  AST_VALID_WITH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |-> vid_adv); // R9
  AST_ADV_IN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    vid_adv |-> ph[7]); // R9
endmodule

bind nibble_dram_seq nds_chk #(.MA_W(MA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .ma(mem_addr), .ras(row_sel),
  .cas(col_sel), .vid_valid(vid_valid), .vid_adv(vid_adv),
  .vid_byte(vid_byte), .cpu_byte(cpu_byte)
);

// File: tb/sim_nibble_dram_seq.sv
`timescale 1ns/1ps
module sim_nibble_dram_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vid_req = 1'b0, cpu_rd = 1'b0, nmi = 1'b0;
  logic [14:0] vid_addr = '0, cpu_addr = '0;
  logic [3:0] dram_nib;
  logic [7:0] mem_addr, vid_byte, cpu_byte;
  logic row_sel, col_sel, vid_valid, vid_adv;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] vq[$];
  logic [7:0] cpu_exp = 8'h00;

  always #2 clk = ~clk;

  nibble_dram_seq u0 (
    .clk(clk), .rst_n(rst_n), .vid_req(vid_req), .vid_addr(vid_addr),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .nmi(nmi), .dram_nib(dram_nib),
    .mem_addr(mem_addr), .row_sel(row_sel), .col_sel(col_sel),
    .vid_byte(vid_byte), .vid_valid(vid_valid), .vid_adv(vid_adv),
    .cpu_byte(cpu_byte)
  );

  // Memory model: contents are a function of the word index {row, column}.
  function automatic logic [3:0] mem_nib(input logic [15:0] idx);
    return idx[3:0] ^ idx[7:4] ^ idx[11:8] ^ idx[15:12] ^ 4'h9;
  endfunction

  function automatic logic [7:0] byte_at(input logic [14:0] a);
    logic [7:0] r;
    logic [6:0] c;
    r = a[14:7];
    c = a[6:0];
    return {mem_nib({r, c, 1'b0}), mem_nib({r, c, 1'b1})};
  endfunction

  logic [7:0] row_l = '0, col_l = '0, ma_d = '0;
  logic ras_d = 1'b0, cas_d = 1'b0;
  always @(negedge clk) begin
    if (row_sel && !ras_d) row_l <= ma_d;
    if (col_sel && !cas_d) col_l <= mem_addr;
    ras_d <= row_sel;
    cas_d <= col_sel;
    ma_d  <= mem_addr;
  end
  assign dram_nib = mem_nib({row_l, col_l});

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the expected video byte when the valid pulse appears.
  logic valid_seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (vid_valid) begin
        check(!valid_seen, "R7", "valid width", 32'(valid_seen), 0);
        if (vq.size() == 0) begin
          check(0, "R7", "unexpected valid", 1, 0);
        end else begin
          logic [7:0] e;
          e = vq.pop_front();
          check(vid_byte == e, "R5", "video byte", 32'(vid_byte), 32'(e));
        end
      end
      valid_seen <= vid_valid;
    end
  end

  // Driver: one 8-cycle slot, entered and left on a falling edge.
  task automatic slot(input logic req, input logic [14:0] va, input logic [14:0] ca,
                      input logic rd, input logic inh);
    logic gr;
    logic [14:0] a;
    gr = req && !inh;
    a = gr ? va : ca;
    if (gr) vq.push_back(byte_at(a));
    if (!gr && rd) cpu_exp = byte_at(a);
    vid_req = req; vid_addr = va; cpu_addr = ca; cpu_rd = rd; nmi = inh;
    for (int i = 0; i < 8; i++) begin
      logic e_ras, e_cas;
      logic [7:0] e_ma;
      @(posedge clk);
      @(negedge clk);
      e_ras = (i >= 1 && i <= 6);
      e_cas = (i == 2 || i == 3 || i == 5 || i == 6);
      e_ma  = (i == 0) ? a[14:7] : (i <= 3) ? {a[6:0], 1'b0} : {a[6:0], 1'b1};
      check(row_sel == e_ras, "R3", "row strobe", 32'(row_sel), 32'(e_ras));
      check(col_sel == e_cas, "R3", "column strobe", 32'(col_sel), 32'(e_cas));
      if (i == 0) check(mem_addr == e_ma, "R2", "row address (R6 selection)",
                        32'(mem_addr), 32'(e_ma));
      else check(mem_addr == e_ma, "R4", "column address", 32'(mem_addr), 32'(e_ma));
      if (i == 6) begin
        check(vid_adv == req, "R9", "advance pulse", 32'(vid_adv), 32'(req));
        check(cpu_byte == cpu_exp, "R8", "cpu byte", 32'(cpu_byte), 32'(cpu_exp));
      end else begin
        check(!vid_adv, "R9", "advance idle", 32'(vid_adv), 0);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_addr == 0, "R1", "reset address", 32'(mem_addr), 0);
    check(!row_sel && !col_sel, "R1", "reset strobes", {row_sel, col_sel}, 0);
    check(!vid_valid && !vid_adv, "R1", "reset pulses", {vid_valid, vid_adv}, 0);
    check(cpu_byte == 0, "R1", "reset cpu byte", 32'(cpu_byte), 0);
    rst_n = 1'b1;
    check(mem_addr == 0 && !row_sel, "R1", "cycle 0 after reset", 32'(mem_addr), 0);

    slot(1, 15'h5A3C, 15'h1234, 1, 0);      // R6: video granted, CPU read ignored (R8)
    slot(0, 15'h5A3C, 15'h7F7F, 1, 0);      // R8: CPU read
    slot(1, 15'h2222, 15'h0001, 1, 1);      // R9: fetch blocked by nmi, CPU read instead
    slot(0, 15'h3333, 15'h4C4C, 0, 0);      // R8: no read, cpu byte holds
    slot(1, 15'h7FFF, 15'h0000, 0, 0);      // boundaries of the address fields
    slot(1, 15'h0000, 15'h7FFF, 0, 0);
    slot(1, 15'h007F, 15'h0000, 1, 0);
    slot(1, 15'h0080, 15'h0000, 1, 0);
    slot(0, 15'h0000, 15'h6D01, 1, 1);      // nmi without request: plain CPU read
    for (int k = 0; k < 4; k++) slot(1, 15'(15'h5800 + 8 * k), 15'h0100, 0, 0);
    slot(1, 15'h1111, 15'h0ABC, 1, 1);      // R9 again, then R7: no valid
    repeat (2) @(negedge clk);
    check(vq.size() == 0, "R7", "pending video bytes", 32'(vq.size()), 0);
    finish_run();
  end
endmodule